// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, every clock cycle, which hardware threads of a multithreaded core may fetch. It looks at a status code and an active bit for each thread, at a policy select, and at per-thread occupancy counts for the issue queue and for the load/store queue. It produces up to `NSEL` selections per cycle. Each selection is a thread ID with a valid flag, and slot 0 holds the first choice.

The selections are combinational from the inputs and the stored round-robin order. A thread takes part only when its active bit is set and its status says it can fetch.

Four policies are offered:
- **Single:** looks only at the lowest-numbered active thread.
- **Round-robin:** walks a stored order of thread IDs. The threads it picks move to the tail of that order at the next clock edge.
- **Issue-queue count:** favours the thread with the least issue-queue occupancy.
- **Load/store-queue count:** favours the thread with the least load/store-queue occupancy.

Top module: `fetch_thread_pick`

## Requirements
- R1: A thread is eligible only when its active bit is 1 and its 3-bit status is 0 (running), 1 (idle) or 2 (fill complete). Status codes 3 to 7 make it ineligible.
- R2: With policy 1 (round-robin), the slots take the first `NSEL` eligible threads in stored-order position order, slot 0 first.
- R3: After a round-robin cycle with at least one valid slot, the new order takes effect from the next cycle. It lists the unpicked threads in their previous relative order, followed by the picked threads in slot order.
- R4: The stored order is unchanged after any cycle whose policy is not round-robin, and after any round-robin cycle with no valid slot.
- R5: Valid slots are contiguous from slot 0. When fewer threads are eligible than there are slots, the trailing slots are invalid. With no eligible thread, all slots are invalid. An invalid slot reports thread ID 0.
- R6: With policy 0 (single), only the lowest-numbered active thread is considered. It goes to slot 0 if it is eligible. Otherwise no slot is valid, even when another thread is eligible. Slots above 0 are always invalid.
- R7: With policy 2 (issue-queue count), each slot in turn takes the not-yet-picked eligible thread with the smallest issue-queue occupancy. A tie goes to the lower thread ID.
- R8: With policy 3 (load/store-queue count), the same rule as R7 applies, using the load/store-queue occupancy.
- R9: After reset, the stored order is thread IDs in ascending order.
- R10: In every cycle, the valid slots hold distinct thread IDs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_state | input | NT*3 | Per-thread status code; thread t uses bits [3t+2:3t] |
| thr_active | input | NT | Per-thread active bit |
| policy | input | 2 | 0 single, 1 round-robin, 2 issue-queue count, 3 load/store-queue count |
| iq_occ | input | NT*CNT_W | Per-thread issue-queue occupancy; thread t at [CNT_W*t +: CNT_W] |
| lsq_occ | input | NT*CNT_W | Per-thread load/store-queue occupancy, same layout |
| sel_tid | output | NSEL*TID_W | Selected thread ID per slot; slot k at [TID_W*k +: TID_W] |
| sel_valid | output | NSEL | Per-slot valid flag |

## Verification
All selections depend combinationally on the inputs of the same cycle and are due in that cycle. A change to the round-robin order from a valid selection first shows up in the selections of the next cycle.

The bench drives inputs just after the falling edge and compares every slot one nanosecond later, still before the rising edge. Its behavioural queue model of the order is updated only at the rising edge. In this way each result is compared exactly in the cycle it is due, and order effects are compared one cycle later.

// File: rtl/fsel_pkg.sv
// Shared types for the fetch thread selector.
// Assumes a 3-bit thread status code and a 2-bit policy select.
package fsel_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_IDLE       = 3'd1,
        ST_FILL_DONE  = 3'd2,
        ST_BLOCKED    = 3'd3,
        ST_SQUASH     = 3'd4,
        ST_XLATE_WAIT = 3'd5,
        ST_FILL_WAIT  = 3'd6,
        ST_TRAP       = 3'd7
    } thr_state_e;

    typedef enum logic [1:0] {
        POL_SINGLE = 2'd0,
        POL_RR     = 2'd1,
        POL_IQ     = 2'd2,
        POL_LSQ    = 2'd3
    } pick_pol_e;

    localparam int STATE_W = 3;

    // True for the status codes that allow a thread to fetch.
    function automatic logic state_can_fetch(input logic [STATE_W-1:0] s);
        return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_FILL_DONE);
    endfunction

endpackage

// File: rtl/fsel_elig.sv
// Per-thread eligibility: active and in a status that permits fetch.
// Assumes status codes are packed 3 bits per thread, thread 0 lowest.
module fsel_elig
    import fsel_pkg::*;
#(
    parameter int NT = 4
) (
    input  logic [NT*STATE_W-1:0] thr_state,
    input  logic [NT-1:0]         thr_active,
    output logic [NT-1:0]         elig
);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        // Combine active bit with the status decode for thread t.
        assign elig[t] = thr_active[t] && state_can_fetch(thr_state[t*STATE_W +: STATE_W]);
    end

endmodule

// File: rtl/fsel_rr_list.sv
// Round-robin order store and picker. Holds an ordered list of thread IDs,
// picks the first NSEL eligible entries in list order and, when enabled and
// at least one pick is made, moves the picked IDs to the tail in pick order.
// Assumes NT >= 2 so thread IDs are at least one bit wide.
module fsel_rr_list #(
    parameter int NT    = 4,
    parameter int NSEL  = 2,
    parameter int TID_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NT-1:0]         elig,
    input  logic                  rr_mode,
    output logic [NSEL*TID_W-1:0] pick_tid,
    output logic [NSEL-1:0]       pick_vld
);

    logic [TID_W-1:0] order_q [NT];
    logic [TID_W-1:0] order_d [NT];
    logic [NT-1:0]    taken;
    logic [TID_W-1:0] last_tid;
    logic             upd;
    logic [NT*TID_W-1:0] order_flat;
    logic [NT*TID_W-1:0] asc_flat;

    // Scan the list in order and claim the first NSEL eligible entries.
    always_comb begin
        int n;
        n        = 0;
        taken    = '0;
        pick_tid = '0;
        pick_vld = '0;
        last_tid = '0;
        for (int p = 0; p < NT; p++) begin
            if (elig[order_q[p]] && (n < NSEL)) begin
                taken[p]                     = 1'b1;
                pick_tid[n*TID_W +: TID_W]   = order_q[p];
                pick_vld[n]                  = 1'b1;
                last_tid                     = order_q[p];
                n++;
            end
        end
    end

    // Build the next order: unpicked entries first, then picked ones.
    always_comb begin
        int w;
        w = 0;
        for (int p = 0; p < NT; p++) order_d[p] = '0;
        for (int p = 0; p < NT; p++) begin
            if (!taken[p]) begin
                order_d[w] = order_q[p];
                w++;
            end
        end
        for (int p = 0; p < NT; p++) begin
            if (taken[p]) begin
                order_d[w] = order_q[p];
                w++;
            end
        end
    end

    assign upd = rr_mode && (|pick_vld);

    // Order register: ascending IDs at reset, rotated on a valid pick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NT; p++) order_q[p] <= TID_W'(p);
        end else if (upd) begin
            for (int p = 0; p < NT; p++) order_q[p] <= order_d[p];
        end
    end

    for (genvar p = 0; p < NT; p++) begin : g_flat
        // Flattened views of the order for the checks below.
        assign order_flat[p*TID_W +: TID_W] = order_q[p];
        assign asc_flat[p*TID_W +: TID_W]   = TID_W'(p);
    end

    // R4: no update means the order holds.
    a_r4_order_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(order_flat));

    // R3: the last picked thread ends up at the tail.
    a_r3_tail: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> order_q[NT-1] == $past(last_tid));

    // R9: the first cycle out of reset sees ascending order.
    a_r9_reset_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> order_flat == asc_flat);

endmodule

// File: rtl/fsel_cnt_pick.sv
// Occupancy-based picker: each slot takes the not-yet-picked eligible thread
// with the smallest count, lower thread ID winning ties.
// Assumes counts are unsigned and packed CNT_W bits per thread.
module fsel_cnt_pick #(
    parameter int NT    = 4,
    parameter int NSEL  = 2,
    parameter int TID_W = 2,
    parameter int CNT_W = 4
) (
    input  logic [NT-1:0]         elig,
    input  logic [NT*CNT_W-1:0]   occ,
    output logic [NSEL*TID_W-1:0] pick_tid,
    output logic [NSEL-1:0]       pick_vld
);

    // Repeated minimum search, excluding threads already placed in a slot.
    always_comb begin
        logic [NT-1:0]    used;
        logic             found;
        int               best;
        logic [CNT_W-1:0] best_cnt;
        used     = '0;
        pick_tid = '0;
        pick_vld = '0;
        for (int s = 0; s < NSEL; s++) begin
            found    = 1'b0;
            best     = 0;
            best_cnt = '0;
            for (int t = 0; t < NT; t++) begin
                if (elig[t] && !used[t] &&
                    (!found || (occ[t*CNT_W +: CNT_W] < best_cnt))) begin
                    found    = 1'b1;
                    best     = t;
                    best_cnt = occ[t*CNT_W +: CNT_W];
                end
            end
            if (found) begin
                used[best]                 = 1'b1;
                pick_tid[s*TID_W +: TID_W] = TID_W'(best);
                pick_vld[s]                = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fetch_thread_pick.sv
// Fetch thread selector top. Computes eligibility, runs the round-robin,
// occupancy and single-thread pickers, and forwards the one named by the
// policy select. Selections are combinational; only the round-robin order
// is stored. Assumes NT >= 2 and 1 <= NSEL <= NT.
module fetch_thread_pick
    import fsel_pkg::*;
#(
    parameter int NT    = 4,
    parameter int NSEL  = 2,
    parameter int CNT_W = 4,
    localparam int TID_W = $clog2(NT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NT*3-1:0]       thr_state,
    input  logic [NT-1:0]         thr_active,
    input  logic [1:0]            policy,
    input  logic [NT*CNT_W-1:0]   iq_occ,
    input  logic [NT*CNT_W-1:0]   lsq_occ,
    output logic [NSEL*TID_W-1:0] sel_tid,
    output logic [NSEL-1:0]       sel_valid
);

    logic [NT-1:0]         elig;
    logic [NSEL*TID_W-1:0] rr_tid, cnt_tid, one_tid;
    logic [NSEL-1:0]       rr_vld, cnt_vld, one_vld;
    logic [NT*CNT_W-1:0]   occ_sel;

    fsel_elig #(.NT(NT)) u_elig (
        .thr_state (thr_state),
        .thr_active(thr_active),
        .elig      (elig)
    );

    fsel_rr_list #(.NT(NT), .NSEL(NSEL), .TID_W(TID_W)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .rr_mode (policy == POL_RR),
        .pick_tid(rr_tid),
        .pick_vld(rr_vld)
    );

    // Pick the occupancy vector named by the policy.
    assign occ_sel = (policy == POL_LSQ) ? lsq_occ : iq_occ;

    fsel_cnt_pick #(.NT(NT), .NSEL(NSEL), .TID_W(TID_W), .CNT_W(CNT_W)) u_cnt (
        .elig    (elig),
        .occ     (occ_sel),
        .pick_tid(cnt_tid),
        .pick_vld(cnt_vld)
    );

    // Single-thread pick: lowest active thread, valid only if eligible.
    always_comb begin
        int first;
        first   = 0;
        one_tid = '0;
        one_vld = '0;
        for (int t = NT - 1; t >= 0; t--) begin
            if (thr_active[t]) first = t;
        end
        if ((|thr_active) && elig[first]) begin
            one_tid[TID_W-1:0] = TID_W'(first);
            one_vld[0]         = 1'b1;
        end
    end

    // Output select by policy.
    always_comb begin
        unique case (pick_pol_e'(policy))
            POL_SINGLE: begin sel_tid = one_tid; sel_valid = one_vld; end
            POL_RR:     begin sel_tid = rr_tid;  sel_valid = rr_vld;  end
            default:    begin sel_tid = cnt_tid; sel_valid = cnt_vld; end
        endcase
    end

    // R5: nothing eligible gives no valid slot.
    a_r5_none: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |-> (sel_valid == '0));

    // R6: single policy never fills more than one slot.
    a_r6_single_one: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_SINGLE) |-> ($countones(sel_valid) <= 1));

    for (genvar k = 0; k < NSEL; k++) begin : g_slot
        // R1: a valid slot names an eligible thread.
        a_r1_slot_elig: assert property (@(posedge clk) disable iff (!rst_n)
            sel_valid[k] |-> elig[sel_tid[k*TID_W +: TID_W]]);
        // R5: an invalid slot reports ID 0.
        a_r5_zero_tid: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_valid[k] |-> (sel_tid[k*TID_W +: TID_W] == '0));
        if (k + 1 < NSEL) begin : g_next
            // R5: valid slots are contiguous from slot 0.
            a_r5_contig: assert property (@(posedge clk) disable iff (!rst_n)
                !sel_valid[k] |-> !sel_valid[k+1]);
        end
        for (genvar j = k + 1; j < NSEL; j++) begin : g_pair
            // R10: two valid slots never share a thread.
            a_r10_distinct: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_valid[k] && sel_valid[j]) |->
                (sel_tid[k*TID_W +: TID_W] != sel_tid[j*TID_W +: TID_W]));
        end
    end

endmodule

// File: tb/test_fetch_thread_pick.sv
`timescale 1ns/100ps
module test_fetch_thread_pick;

    localparam int NT    = 4;
    localparam int NSEL  = 2;
    localparam int CNT_W = 4;
    localparam int TID_W = 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NT*3-1:0]       thr_state = '0;
    logic [NT-1:0]         thr_active = '0;
    logic [1:0]            policy = 2'd1;
    logic [NT*CNT_W-1:0]   iq_occ = '0;
    logic [NT*CNT_W-1:0]   lsq_occ = '0;
    logic [NSEL*TID_W-1:0] sel_tid;
    logic [NSEL-1:0]       sel_valid;

    int total = 0;
    int bad   = 0;
    int order[$];
    int picked[$];
    int exp_tid[NSEL];
    bit exp_vld[NSEL];

    always #2.5 clk = ~clk;

    fetch_thread_pick #(.NT(NT), .NSEL(NSEL), .CNT_W(CNT_W)) i_fetch_thread_pick (
        .clk(clk), .rst_n(rst_n), .thr_state(thr_state), .thr_active(thr_active),
        .policy(policy), .iq_occ(iq_occ), .lsq_occ(lsq_occ),
        .sel_tid(sel_tid), .sel_valid(sel_valid)
    );

    function automatic bit can_fetch(int t);
        int s;
        s = int'(thr_state[t*3 +: 3]);
        return thr_active[t] && (s <= 2);
    endfunction

    function automatic int occ_of(int t);
        if (policy == 2'd3) return int'(lsq_occ[t*CNT_W +: CNT_W]);
        return int'(iq_occ[t*CNT_W +: CNT_W]);
    endfunction

    // Expected slots from the current inputs and the model order.
    task automatic compute();
        bit used[NT];
        picked.delete();
        for (int k = 0; k < NSEL; k++) begin exp_tid[k] = 0; exp_vld[k] = 0; end
        for (int t = 0; t < NT; t++) used[t] = 0;
        if (policy == 2'd0) begin
            int f;
            f = -1;
            for (int t = 0; t < NT; t++) if (f < 0 && thr_active[t]) f = t;
            if (f >= 0 && can_fetch(f)) begin exp_tid[0] = f; exp_vld[0] = 1; end
        end else if (policy == 2'd1) begin
            foreach (order[p]) begin
                if (can_fetch(order[p]) && picked.size() < NSEL) begin
                    exp_tid[picked.size()] = order[p];
                    exp_vld[picked.size()] = 1;
                    picked.push_back(order[p]);
                end
            end
        end else begin
            for (int k = 0; k < NSEL; k++) begin
                int b;
                b = -1;
                for (int t = 0; t < NT; t++)
                    if (can_fetch(t) && !used[t] && (b < 0 || occ_of(t) < occ_of(b))) b = t;
                if (b >= 0) begin used[b] = 1; exp_tid[k] = b; exp_vld[k] = 1; end
            end
        end
    endtask

    task automatic check_slots(string tag);
        for (int k = 0; k < NSEL; k++) begin
            int at;
            at = int'(sel_tid[k*TID_W +: TID_W]);
            total++;
            if (sel_valid[k] !== exp_vld[k] || at != exp_tid[k]) begin
                bad++;
                $display("FAIL %s slot %0d: valid=%0d tid=%0d expected valid=%0d tid=%0d",
                         tag, k, sel_valid[k], at, exp_vld[k], exp_tid[k]);
            end
        end
    endtask

    // One cycle: settle, compare, clock, update the model order.
    task automatic step(string tag);
        int nxt[$];
        #1;
        compute();
        check_slots(tag);
        @(posedge clk);
        if (policy == 2'd1 && picked.size() > 0) begin
            foreach (order[p]) begin
                bit was;
                was = 0;
                foreach (picked[q]) if (picked[q] == order[p]) was = 1;
                if (!was) nxt.push_back(order[p]);
            end
            foreach (picked[q]) nxt.push_back(picked[q]);
            order = nxt;
        end
        @(negedge clk);
    endtask

    task automatic set_st(int t, int v);
        thr_state[t*3 +: 3] = 3'(v);
    endtask

    task automatic set_occ(int a0, int a1, int a2, int a3, bit lsq);
        logic [NT*CNT_W-1:0] v;
        v = {CNT_W'(a3), CNT_W'(a2), CNT_W'(a1), CNT_W'(a0)};
        if (lsq) lsq_occ = v; else iq_occ = v;
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < NT; t++) order.push_back(t);
        thr_active = '1;
        thr_state  = '0;
        policy     = 2'd1;
        step("R9");                          // expect 0,1
        step("R3");                          // expect 2,3
        step("R3");                          // expect 0,1 again

        // R1: each ineligible code, and an inactive running thread
        for (int c = 3; c < 8; c++) begin
            set_st(0, c); set_st(1, 0); set_st(2, 1); set_st(3, 2);
            thr_active = 4'b1111;
            step("R1");
        end
        thr_state = '0; thr_active = 4'b1010;
        step("R1");

        // R4: a count cycle and an empty round-robin cycle leave the order
        thr_active = '1; thr_state = '0; policy = 2'd2; set_occ(1, 2, 3, 4, 0);
        step("R7");
        policy = 2'd1;
        step("R4");
        thr_active = '0;
        step("R5");
        thr_active = '1;
        step("R4");

        // R5: a single eligible thread fills only slot 0
        thr_state = '0; set_st(0, 3); set_st(1, 6); set_st(3, 7);
        step("R5");

        // R6: lowest active thread blocked while another is ready
        policy = 2'd0; thr_active = 4'b1110; thr_state = '0; set_st(1, 4);
        step("R6");
        set_st(1, 2);
        step("R6");

        // R7 and R8: ties go to lower ID, second slot takes next minimum
        thr_active = '1; thr_state = '0;
        policy = 2'd2; set_occ(5, 3, 3, 9, 0); set_occ(0, 7, 7, 7, 1);
        step("R7");
        policy = 2'd3;
        step("R8");
        set_occ(2, 1, 0, 0, 1); set_st(2, 5);
        step("R8");

        // Mixed random traffic across all policies
        for (int i = 0; i < 3000; i++) begin
            policy = 2'($urandom_range(0, 3));
            thr_active = NT'($urandom);
            for (int t = 0; t < NT; t++)
                set_st(t, ($urandom_range(0, 1) == 0) ? $urandom_range(0, 2) : $urandom_range(0, 7));
            iq_occ  = (NT*CNT_W)'($urandom);
            lsq_occ = (NT*CNT_W)'($urandom);
            case (policy)
                2'd0: step("R6");
                2'd1: step("R2");
                2'd2: step("R7");
                default: step("R8");
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule